// File: doc/BRIEF.md
# Dual-Bank GPIO Port Controller

This block is a register-mapped general-purpose I/O controller for two banks of 32 pins. Each pin has an output-data bit and a direction bit. Software can load either word directly. It can also use write-one-only set, clear and toggle locations, which change only the bits written as 1. Several drivers can therefore work on different pins of one bank without a read-modify-write sequence. The bank bit for pin n is `1 << n`.

The bus is a simple synchronous register port: address, write enable, write data, and read data. Read data is combinational from the current address. Each bank has a pin-level readback location. It returns what the pads actually carry, after a two-flop synchronizer, and not what the controller drives. Pad outputs leave on flat vectors in which bank b, pin n sits at bit `b*32+n`.

Address layout: bit 3 selects the bank and bits 2:0 select the register. The registers are:

- 0: output word (read/write)
- 1: set
- 2: clear
- 3: toggle
- 4: direction word (read/write)
- 5: direction set
- 6: direction clear
- 7: pin level (read only)

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset all output bits and all direction bits are 0, and every readable location returns 0 while the pads are held at 0.
- R2: A write to offset 0 loads the whole output word of the addressed bank; it appears on `pad_out` after that clock edge and reads back at offset 0.
- R3: A write to offset 1 sets every output bit whose write-data bit is 1 and leaves bits whose write-data bit is 0 unchanged.
- R4: A write to offset 2 clears every output bit whose write-data bit is 1 and leaves the others unchanged.
- R5: A write to offset 3 inverts every output bit whose write-data bit is 1 and leaves the others unchanged.
- R6: Offset 4 loads the direction word, and direction 1 means the pin drives, shown on `pad_oe`. Offset 5 makes masked pins outputs, offset 6 makes masked pins inputs, and unmasked pins keep their direction. Offset 4 reads back the direction word.
- R7: Offset 7 returns the pad level after two rising clock edges of synchronization, independent of the driven output value.
- R8: Offsets 1, 2, 3, 5 and 6 always read as 0, and a write to offset 7 changes neither output nor direction state.
- R9: Address bit 3 selects the bank, and a write to one bank leaves the other bank's output and direction bits unchanged.
- R10: Pin n of bank b is bit n of that bank's register word and bit `b*32+n` of `pad_out` and `pad_oe`; for example, mask 0b1000 addresses pin 3.
- R11: Without a write enable, no output or direction bit changes, whatever the address and write data are.
- R12: The direction bits do not alter the output-data value; `pad_out` shows the output register even for pins configured as inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address, bank in the top bit |
| bus_we | input | 1 | Write enable for the addressed register |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Read data for the current address |
| pad_out | output | 64 | Output-data bits of both banks |
| pad_oe | output | 64 | Output-enable (direction) bits of both banks |
| pad_in | input | 64 | Levels observed at the pads |

## Verification
Some behaviours are checked by assertions on every cycle:

- the masked effect of set, clear, toggle and direction set/clear writes;
- that no state moves without a write, or on a write to the pin-level location;
- the isolation of one bank from writes to the other;
- the two-edge delay of the pad synchronizer.

The bench's scenarios are needed for the rest: the reset contents, the address map itself, the zero readback of write-only locations, and the bit positions on the flat pad vectors. The independent per-cycle model covers all of these, including the difference between the driven value and the pad level.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   // register selector, low three address bits
   typedef enum logic [2:0] {
      REG_OUT  = 3'd0,
      REG_SET  = 3'd1,
      REG_CLR  = 3'd2,
      REG_TGL  = 3'd3,
      REG_DIR  = 3'd4,
      REG_DSET = 3'd5,
      REG_DCLR = 3'd6,
      REG_PIN  = 3'd7
   } gpio_reg_e;

   localparam int unsigned SEL_W = 3;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

   // cycles since reset, saturating; gates the delay check
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                since_rst <= '0;
      else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
   end

   generate
      if (STAGES == 2) begin : g_two_stage_chk
         p_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd2) |-> (q == $past(d, 2)));
      end
   endgenerate

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_pkg::*;
#(
   parameter int unsigned PINS = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  gpio_reg_e       sel,
   input  logic [PINS-1:0] wdata,
   output logic [PINS-1:0] out_q,
   output logic [PINS-1:0] dir_q
);

   logic [PINS-1:0] out_nxt;
   logic [PINS-1:0] dir_nxt;

   // one selector per cycle: each location drives exactly one update path
   always_comb begin
      out_nxt = out_q;
      dir_nxt = dir_q;
      if (wr) begin
         case (sel)
            REG_OUT:  out_nxt = wdata;
            REG_SET:  out_nxt = out_q | wdata;
            REG_CLR:  out_nxt = out_q & ~wdata;
            REG_TGL:  out_nxt = out_q ^ wdata;
            REG_DIR:  dir_nxt = wdata;
            REG_DSET: dir_nxt = dir_q | wdata;
            REG_DCLR: dir_nxt = dir_q & ~wdata;
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         dir_q <= '0;
      end else begin
         out_q <= out_nxt;
         dir_q <= dir_nxt;
      end
   end

   p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == REG_SET) |=>
         ((out_q & $past(wdata)) == $past(wdata)) &&
         ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));

   p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == REG_CLR) |=>
         ((out_q & $past(wdata)) == '0) &&
         ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));

   p_tgl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == REG_TGL) |=> (out_q == ($past(out_q) ^ $past(wdata))));

   p_dset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == REG_DSET) |=>
         ((dir_q & $past(wdata)) == $past(wdata)) && $stable(out_q));

   p_dclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == REG_DCLR) |=>
         ((dir_q & $past(wdata)) == '0) && $stable(out_q));

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(out_q) && $stable(dir_q));

   p_pinwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == REG_PIN) |=> $stable(out_q) && $stable(dir_q));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 2,
   parameter int unsigned PINS        = 32,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int unsigned ADDR_W     = SEL_W + BANK_W,
   localparam int unsigned PAD_W      = NUM_BANKS * PINS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [PINS-1:0]   bus_wdata,
   output logic [PINS-1:0]   bus_rdata,
   output logic [PAD_W-1:0]  pad_out,
   output logic [PAD_W-1:0]  pad_oe,
   input  logic [PAD_W-1:0]  pad_in
);

   generate
      if (NUM_BANKS < 1) begin : g_bad_banks
         $error("gpio_port_ctrl: NUM_BANKS must be at least 1");
      end
      if (PINS < 1 || PINS > 64) begin : g_bad_pins
         $error("gpio_port_ctrl: PINS must lie in 1..64");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_port_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [BANK_W-1:0] bank_idx;
   gpio_reg_e         sel;
   logic [PAD_W-1:0]  pin_lvl;

   assign bank_idx = bus_addr[ADDR_W-1:SEL_W];
   assign sel      = gpio_reg_e'(bus_addr[SEL_W-1:0]);

   gpio_sync #(.W(PAD_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_lvl)
   );

   logic [PINS-1:0] out_w [NUM_BANKS];
   logic [PINS-1:0] dir_w [NUM_BANKS];

   for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
      logic wr_b;
      assign wr_b = bus_we && (bank_idx == BANK_W'(b));

      gpio_bank #(.PINS(PINS)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (wr_b),
         .sel   (sel),
         .wdata (bus_wdata),
         .out_q (out_w[b]),
         .dir_q (dir_w[b])
      );

      assign pad_out[b*PINS +: PINS] = out_w[b];
      assign pad_oe [b*PINS +: PINS] = dir_w[b];

      p_bank_iso_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bank_idx != BANK_W'(b)) |=>
            $stable(pad_out[b*PINS +: PINS]) && $stable(pad_oe[b*PINS +: PINS]));
   end

   // read path: state words and synchronized pad levels; write-only slots give 0
   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < int'(NUM_BANKS); b++) begin
         if (bank_idx == BANK_W'(b)) begin
            case (sel)
               REG_OUT: bus_rdata = out_w[b];
               REG_DIR: bus_rdata = dir_w[b];
               REG_PIN: bus_rdata = pin_lvl[b*PINS +: PINS];
               default: bus_rdata = '0;
            endcase
         end
      end
   end

endmodule

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;

   localparam int CLK_NS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] pad_out;
   logic [63:0] pad_oe;
   logic [63:0] pad_in = '0;

   int    vectors = 0;
   int    fails   = 0;
   bit    done    = 1'b0;
   string cur_tag = "R1";

   always #(CLK_NS/2) clk = ~clk;

   gpio_port_ctrl u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .pad_in    (pad_in)
   );

   // behavioural reference: per-bank words and a queue of pad samples
   logic [31:0] m_out [2];
   logic [31:0] m_dir [2];
   logic [63:0] padq [$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_out[0] = '0; m_out[1] = '0;
         m_dir[0] = '0; m_dir[1] = '0;
         padq = {};
         padq.push_front(64'h0);
         padq.push_front(64'h0);
      end else begin
         if (bus_we) begin
            case (bus_addr[2:0])
               3'd0: m_out[bus_addr[3]] = bus_wdata;
               3'd1: m_out[bus_addr[3]] = m_out[bus_addr[3]] | bus_wdata;
               3'd2: m_out[bus_addr[3]] = m_out[bus_addr[3]] & ~bus_wdata;
               3'd3: m_out[bus_addr[3]] = m_out[bus_addr[3]] ^ bus_wdata;
               3'd4: m_dir[bus_addr[3]] = bus_wdata;
               3'd5: m_dir[bus_addr[3]] = m_dir[bus_addr[3]] | bus_wdata;
               3'd6: m_dir[bus_addr[3]] = m_dir[bus_addr[3]] & ~bus_wdata;
               default: ;
            endcase
         end
         padq.push_front(pad_in);
         void'(padq.pop_back());
      end
   end

   function automatic logic [31:0] exp_read(input logic [3:0] a);
      logic [63:0] lvl;
      lvl = padq[1];
      case (a[2:0])
         3'd0:    return m_out[a[3]];
         3'd4:    return m_dir[a[3]];
         3'd7:    return a[3] ? lvl[63:32] : lvl[31:0];
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (!done && padq.size() == 2) begin
         chk(cur_tag, "pad_out", pad_out, {m_out[1], m_out[0]});
         chk(cur_tag, "pad_oe", pad_oe, {m_dir[1], m_dir[0]});
         chk(cur_tag, "rdata", {32'h0, bus_rdata}, {32'h0, exp_read(bus_addr)});
      end
   end

   function automatic string tag_of(input int s, input bit wr);
      if (wr) begin
         case (s)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            7: return "R8";
            default: return "R6";
         endcase
      end
      case (s)
         0: return "R2";
         4: return "R6";
         7: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic op(input int b, input int s, input logic [31:0] d, input bit wr);
      @(posedge clk);
      #1;
      bus_we    = wr;
      bus_addr  = {b[0], s[2:0]};
      bus_wdata = d;
      cur_tag   = tag_of(s, wr);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   initial begin
      #(CLK_NS * 150000);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired, actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset contents
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      for (int b = 0; b < 2; b++)
         for (int s = 0; s < 8; s++) begin
            op(b, s, 32'h0, 1'b0);
            cur_tag = "R1";
         end

      // R2: whole-word loads, both banks
      op(0, 0, 32'hA5A5_0F0F, 1'b1);
      op(1, 0, 32'h1234_5678, 1'b1);
      op(0, 0, 32'h0, 1'b0);
      op(1, 0, 32'h0, 1'b0);

      // R3: set, including an all-zero mask
      op(0, 1, 32'h8000_00F0, 1'b1);
      op(0, 1, 32'h0, 1'b1);
      // R4: clear
      op(0, 2, 32'hA000_000F, 1'b1);
      // R5: toggle
      op(0, 3, 32'hFFFF_0000, 1'b1);
      op(0, 3, 32'hFFFF_0000, 1'b1);

      // R10: mask 0b1000 is pin 3 of bank 1, bit 35 of the pad vector
      op(1, 0, 32'h0, 1'b1);
      op(1, 1, 32'h0000_0008, 1'b1);
      op(1, 0, 32'h0, 1'b0);
      @(negedge clk);
      chk("R10", "pad_out[35]", {63'h0, pad_out[35]}, 64'h1);
      chk("R10", "pad_out[34]", {63'h0, pad_out[34]}, 64'h0);

      // R6 and R12: direction control, data value kept for input pins
      op(0, 5, 32'h0000_8001, 1'b1);
      op(0, 6, 32'h0000_0001, 1'b1);
      op(1, 4, 32'hFFFF_0000, 1'b1);
      op(0, 4, 32'h0, 1'b0);
      op(1, 4, 32'h0, 1'b0);
      op(1, 6, 32'hFFFF_FFFF, 1'b1);
      op(1, 1, 32'h0000_0100, 1'b1);
      op(1, 0, 32'h0, 1'b0);
      @(negedge clk);
      chk("R12", "pad_out[40] with pin as input", {63'h0, pad_out[40]}, 64'h1);
      chk("R12", "pad_oe bank1", {32'h0, pad_oe[63:32]}, 64'h0);

      // R8: write-only locations read 0; write to pin location ignored
      for (int b = 0; b < 2; b++)
         for (int s = 1; s < 7; s++)
            if (s != 4) op(b, s, 32'h0, 1'b0);
      op(0, 7, 32'hFFFF_FFFF, 1'b1);
      op(1, 7, 32'hFFFF_FFFF, 1'b1);

      // R11: no write enable, busy address and data
      op(0, 1, 32'hFFFF_FFFF, 1'b0);
      cur_tag = "R11";
      op(1, 2, 32'hFFFF_FFFF, 1'b0);
      cur_tag = "R11";
      op(0, 0, 32'h5555_5555, 1'b0);
      cur_tag = "R11";

      // R7: pad levels, distinct from driven values, two-edge latency
      op(0, 7, 32'h0, 1'b0);
      pad_in = 64'hDEAD_BEEF_0BAD_F00D;
      op(0, 7, 32'h0, 1'b0);
      op(0, 7, 32'h0, 1'b0);
      op(1, 7, 32'h0, 1'b0);
      pad_in = 64'h0123_4567_89AB_CDEF;
      op(1, 7, 32'h0, 1'b0);
      op(1, 7, 32'h0, 1'b0);
      op(0, 7, 32'h0, 1'b0);
      @(negedge clk);
      chk("R7", "pin level bank0", {32'h0, bus_rdata}, 64'h0000_0000_89AB_CDEF);

      // mixed traffic (R9 bank isolation across all of it)
      for (int n = 0; n < 400; n++) begin
         op(int'($urandom % 2), int'($urandom % 8), $urandom, 1'($urandom % 2));
         if ((n % 5) == 0) pad_in = {$urandom, $urandom};
      end
      op(0, 0, 32'h0, 1'b0);
      op(1, 0, 32'h0, 1'b0);
      cur_tag = "R9";
      @(negedge clk);
      #1;

      done = 1'b1;
      summary();
      $finish;
   end

endmodule